// File: doc/BRIEF.md
# Flag Offset Register Port with Stepping Pointers

This block holds the two threshold offsets used by a FIFO's almost-empty and almost-full flags. Each offset is split into byte-sized slices of one data word, and software reaches these slices one word at a time through the FIFO's own data pins. A write-side pointer walks the slices on the write clock, so every qualified write lands in the next slice. A read-side pointer walks the same slices on the read clock, and every qualified read copies the selected slice into the output word register. The two pointers are fully independent.

Either sequence may be paused at any slice by raising the load strobe or the relevant enable. Ordinary FIFO traffic can run in between, and the next qualified access continues with the following slice. The assembled offsets leave the block as two wide buses, each with a validity flag. The flag goes low while that offset is being reprogrammed and comes back once its final slice is in. The number of slices per offset (two or three) and the slice width are parameters.

Top module: `offset_seq_regs`

## Requirements
- R1: When `ld_n` and `wen_n` are both low at a rising `wr_clk` edge, `din` is stored in the slice the write pointer selects, and the write pointer moves to the next slice.
- R2: Slice order is: empty-offset slices from least to most significant, then full-offset slices from least to most significant. After the last full slice the order wraps to the empty least significant slice. Slice k of an offset occupies bits [k*SLICE_W +: SLICE_W] of `empty_ofs` or `full_ofs`.
- R3: When `ld_n` and `ren_n` are both low at a rising `rd_clk` edge, `dout` takes the slice the read pointer selects, and the read pointer advances. It uses the same order as R2 but moves independently of the write pointer.
- R4: A read-clock edge with `ld_n` high or `ren_n` high leaves `dout` unchanged.
- R5: A write-clock edge with `ld_n` high or `wen_n` high changes no slice and does not move the write pointer, so the next qualified write continues at the following slice.
- R6: Asserting `mrst` (active high, asynchronous) does four things. It returns both pointers to the empty least significant slice, loads `empty_ofs` with EMPTY_RST and `full_ofs` with FULL_RST, sets both validity flags to 1 and clears `dout` to 0.
- R7: `prst` (active high, sampled on `rd_clk`) clears `dout` to 0. It does not move either pointer and does not change the offsets or the validity flags.
- R8: Writing any full-offset slice other than its most significant one drops `full_ofs_vld` to 0 right after that `wr_clk` edge. After the write of the most significant full slice, `full_ofs_vld` rises on the second following `wr_clk` edge.
- R9: Writing any empty-offset slice other than its most significant one makes `empty_ofs_vld` go to 0. Writing the most significant empty slice makes it return to 1. Both changes appear within two `rd_clk` edges of the write, as seen in the read domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| prst | input | 1 | Partial reset, active high, on rd_clk |
| ld_n | input | 1 | Offset access strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | SLICE_W | Input word |
| dout | output | SLICE_W | Output word register |
| empty_ofs | output | SLICE_W*NSLICE | Assembled almost-empty offset |
| full_ofs | output | SLICE_W*NSLICE | Assembled almost-full offset |
| empty_ofs_vld | output | 1 | Almost-empty offset is complete (read domain) |
| full_ofs_vld | output | 1 | Almost-full offset is complete (write domain) |

## Verification
The bench builds the block with three 8-bit slices per offset and reset offsets of 7. This reaches the middle slices and the six-slot order that wraps on the seventh access, which the two-slice default does not touch. With three slices, a read and a write pointer can sit on different slices of different offsets, so the bench can show that they step independently. It can also hold the full offset half-written long enough to watch its validity flag stay low.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  // Slot after p in a ring of nslot slots.
  function automatic int slot_next(input int p, input int nslot);
    return (p == nslot - 1) ? 0 : p + 1;
  endfunction

  // Slots at index nslice and above belong to the full offset.
  function automatic logic slot_is_full(input int p, input int nslice);
    return p >= nslice;
  endfunction

  // True for the most significant slice of either offset.
  function automatic logic slot_is_last(input int p, input int nslice);
    return (p % nslice) == nslice - 1;
  endfunction

endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr
  import ofs_seq_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst)      ptr <= '0;
    else if (step) ptr <= PTR_W'(slot_next(int'(ptr), NSLOT));
  end

endmodule

// File: rtl/ofs_slice_bank.sv
module ofs_slice_bank #(
  parameter int SLICE_W   = 8,
  parameter int NSLICE    = 2,
  parameter int PTR_W     = 2,
  parameter int EMPTY_RST = 7,
  parameter int FULL_RST  = 7,
  localparam int NSLOT    = 2 * NSLICE,
  localparam int OFS_W    = SLICE_W * NSLICE
) (
  input  logic               wr_clk,
  input  logic               mrst,
  input  logic               we,
  input  logic [PTR_W-1:0]   wptr,
  input  logic [SLICE_W-1:0] din,
  input  logic [PTR_W-1:0]   rptr,
  output logic [SLICE_W-1:0] rd_word,
  output logic [OFS_W-1:0]   empty_ofs,
  output logic [OFS_W-1:0]   full_ofs
);

  localparam logic [OFS_W-1:0] E_INIT = OFS_W'(EMPTY_RST);
  localparam logic [OFS_W-1:0] F_INIT = OFS_W'(FULL_RST);

  logic [NSLOT-1:0][SLICE_W-1:0] slots;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int              BYTE = g % NSLICE;
    localparam logic [OFS_W-1:0] SRC = (g < NSLICE) ? E_INIT : F_INIT;
    logic [SLICE_W-1:0] q;

    always_ff @(posedge wr_clk or posedge mrst) begin
      if (mrst)                             q <= SRC[BYTE*SLICE_W +: SLICE_W];
      else if (we && (int'(wptr) == g))     q <= din;
    end

    assign slots[g] = q;
  end

  assign rd_word   = slots[rptr];
  assign empty_ofs = slots[NSLICE-1:0];
  assign full_ofs  = slots[NSLOT-1:NSLICE];

endmodule

// File: rtl/ofs_valid_track.sv
module ofs_valid_track (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic mrst,
  input  logic e_part,
  input  logic e_last,
  input  logic f_part,
  input  logic f_last,
  output logic empty_vld,
  output logic full_vld
);

  logic e_done, e_s1, e_s2;
  logic f_done, f_s1, f_s2;

  always_ff @(posedge wr_clk or posedge mrst) begin
    if (mrst) begin
      e_done <= 1'b1;
      f_done <= 1'b1;
      f_s1   <= 1'b1;
      f_s2   <= 1'b1;
    end else begin
      if (e_part)      e_done <= 1'b0;
      else if (e_last) e_done <= 1'b1;
      if (f_part) begin
        f_done <= 1'b0;
        f_s1   <= 1'b0;
        f_s2   <= 1'b0;
      end else begin
        if (f_last) f_done <= 1'b1;
        f_s1 <= f_done;
        f_s2 <= f_s1;
      end
    end
  end

  // Empty-offset completion is carried into the read domain.
  always_ff @(posedge rd_clk or posedge mrst) begin
    if (mrst) begin
      e_s1 <= 1'b1;
      e_s2 <= 1'b1;
    end else begin
      e_s1 <= e_done;
      e_s2 <= e_s1;
    end
  end

  assign empty_vld = e_s2;
  assign full_vld  = f_s2;

endmodule

// File: rtl/offset_seq_regs.sv
module offset_seq_regs
  import ofs_seq_pkg::*;
#(
  parameter int SLICE_W   = 8,
  parameter int NSLICE    = 2,
  parameter int EMPTY_RST = 7,
  parameter int FULL_RST  = 7,
  localparam int NSLOT    = 2 * NSLICE,
  localparam int PTR_W    = $clog2(NSLOT),
  localparam int OFS_W    = SLICE_W * NSLICE
) (
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               mrst,
  input  logic               prst,
  input  logic               ld_n,
  input  logic               wen_n,
  input  logic               ren_n,
  input  logic [SLICE_W-1:0] din,
  output logic [SLICE_W-1:0] dout,
  output logic [OFS_W-1:0]   empty_ofs,
  output logic [OFS_W-1:0]   full_ofs,
  output logic               empty_ofs_vld,
  output logic               full_ofs_vld
);

  // Named events, visible to the bound checker.
  logic               wr_fire, rd_fire;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [SLICE_W-1:0] rd_word;
  logic               wr_full, wr_last;
  logic               e_part_wr, e_last_wr, f_part_wr, f_last_wr;

  assign wr_fire = !ld_n && !wen_n;
  assign rd_fire = !ld_n && !ren_n;

  assign wr_full   = slot_is_full(int'(wr_ptr), NSLICE);
  assign wr_last   = slot_is_last(int'(wr_ptr), NSLICE);
  assign e_part_wr = wr_fire && !wr_full && !wr_last;
  assign e_last_wr = wr_fire && !wr_full &&  wr_last;
  assign f_part_wr = wr_fire &&  wr_full && !wr_last;
  assign f_last_wr = wr_fire &&  wr_full &&  wr_last;

  ofs_ptr #(.NSLOT(NSLOT), .PTR_W(PTR_W)) u_wptr (
    .clk (wr_clk),
    .mrst(mrst),
    .step(wr_fire),
    .ptr (wr_ptr)
  );

  ofs_ptr #(.NSLOT(NSLOT), .PTR_W(PTR_W)) u_rptr (
    .clk (rd_clk),
    .mrst(mrst),
    .step(rd_fire),
    .ptr (rd_ptr)
  );

  ofs_slice_bank #(
    .SLICE_W  (SLICE_W),
    .NSLICE   (NSLICE),
    .PTR_W    (PTR_W),
    .EMPTY_RST(EMPTY_RST),
    .FULL_RST (FULL_RST)
  ) u_bank (
    .wr_clk   (wr_clk),
    .mrst     (mrst),
    .we       (wr_fire),
    .wptr     (wr_ptr),
    .din      (din),
    .rptr     (rd_ptr),
    .rd_word  (rd_word),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs)
  );

  ofs_valid_track u_vld (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .mrst     (mrst),
    .e_part   (e_part_wr),
    .e_last   (e_last_wr),
    .f_part   (f_part_wr),
    .f_last   (f_last_wr),
    .empty_vld(empty_ofs_vld),
    .full_vld (full_ofs_vld)
  );

  always_ff @(posedge rd_clk or posedge mrst) begin
    if (mrst)         dout <= '0;
    else if (prst)    dout <= '0;
    else if (rd_fire) dout <= rd_word;
  end

endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 2,
  parameter int PTR_W   = 2,
  localparam int NSLOT  = 2 * NSLICE,
  localparam int OFS_W  = SLICE_W * NSLICE
) (
  input logic               wr_clk,
  input logic               rd_clk,
  input logic               mrst,
  input logic               prst,
  input logic               wr_fire,
  input logic               rd_fire,
  input logic [PTR_W-1:0]   wr_ptr,
  input logic [PTR_W-1:0]   rd_ptr,
  input logic               f_part_wr,
  input logic [SLICE_W-1:0] dout,
  input logic [OFS_W-1:0]   empty_ofs,
  input logic [OFS_W-1:0]   full_ofs,
  input logic               full_ofs_vld
);

  p_wptr_step_r1: assert property (@(posedge wr_clk) disable iff (mrst)
    wr_fire |=> wr_ptr != $past(wr_ptr));

  p_ptr_range_r2: assert property (@(posedge wr_clk) disable iff (mrst)
    (int'(wr_ptr) < NSLOT) && (int'(rd_ptr) < NSLOT));

  p_rptr_step_r3: assert property (@(posedge rd_clk) disable iff (mrst)
    rd_fire |=> rd_ptr != $past(rd_ptr));

  p_dout_hold_r4: assert property (@(posedge rd_clk) disable iff (mrst)
    (!rd_fire && !prst) |=> $stable(dout));

  p_ofs_hold_r5: assert property (@(posedge wr_clk) disable iff (mrst)
    !wr_fire |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_ptr)));

  p_prst_clear_r7: assert property (@(posedge rd_clk) disable iff (mrst)
    prst |=> dout == '0);

  p_prst_rptr_r7: assert property (@(posedge rd_clk) disable iff (mrst)
    (prst && !rd_fire) |=> $stable(rd_ptr));

  p_full_drop_r8: assert property (@(posedge wr_clk) disable iff (mrst)
    f_part_wr |=> !full_ofs_vld);

endmodule

bind offset_seq_regs ofs_seq_chk #(
  .SLICE_W(SLICE_W),
  .NSLICE (NSLICE),
  .PTR_W  (PTR_W)
) u_chk (
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .mrst        (mrst),
  .prst        (prst),
  .wr_fire     (wr_fire),
  .rd_fire     (rd_fire),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .f_part_wr   (f_part_wr),
  .dout        (dout),
  .empty_ofs   (empty_ofs),
  .full_ofs    (full_ofs),
  .full_ofs_vld(full_ofs_vld)
);

// File: tb/tb_offset_seq_regs.sv
`timescale 1ns/1ps
module tb_offset_seq_regs;

  localparam int W  = 8;
  localparam int NS = 3;
  localparam int OW = W * NS;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          mrst = 1'b1, prst = 1'b0;
  logic          ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic [OW-1:0] empty_ofs, full_ofs;
  logic          empty_ofs_vld, full_ofs_vld;

  int n_chk = 0, n_bad = 0;

  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  offset_seq_regs #(.SLICE_W(W), .NSLICE(NS), .EMPTY_RST(7), .FULL_RST(7)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .empty_ofs_vld(empty_ofs_vld), .full_ofs_vld(full_ofs_vld)
  );

  typedef struct packed {
    logic         rd;
    logic [W-1:0] data;
  } vec_t;

  // rd=0: write data as next slice; rd=1: read next slice, expect data.
  localparam vec_t VEC [16] = '{
    '{1'b0, 8'h11}, '{1'b0, 8'h22}, '{1'b0, 8'h33},
    '{1'b0, 8'h44}, '{1'b0, 8'h55}, '{1'b0, 8'h66},
    '{1'b1, 8'h11}, '{1'b1, 8'h22}, '{1'b1, 8'h33},
    '{1'b1, 8'h44}, '{1'b1, 8'h55}, '{1'b1, 8'h66},
    '{1'b1, 8'h11}, '{1'b0, 8'hA5}, '{1'b1, 8'h22}, '{1'b1, 8'h33}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_op(input logic [W-1:0] d);
    @(negedge wr_clk);
    ld_n = 1'b0; wen_n = 1'b0; din = d;
    @(posedge wr_clk);
    @(negedge wr_clk);
    ld_n = 1'b1; wen_n = 1'b1;
  endtask

  task automatic rd_op(input logic ld, input logic ren);
    @(negedge wr_clk);
    ld_n = ld; ren_n = ren;
    @(posedge rd_clk);
    @(negedge wr_clk);
    ld_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic wait_rd(input int n);
    for (int i = 0; i < n; i++) @(posedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic do_mrst();
    @(negedge wr_clk);
    mrst = 1'b1;
    @(negedge wr_clk);
    @(negedge wr_clk);
    mrst = 1'b0;
    @(negedge wr_clk);
  endtask

  task automatic reset_state_checks(input string tag);
    check({tag, " empty_ofs"}, 32'(empty_ofs), 32'd7);
    check({tag, " full_ofs"},  32'(full_ofs),  32'd7);
    check({tag, " dout"},      32'(dout),      32'd0);
    check({tag, " empty_vld"}, 32'(empty_ofs_vld), 32'd1);
    check({tag, " full_vld"},  32'(full_ofs_vld),  32'd1);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    mrst = 1'b0;
    @(negedge wr_clk);
    reset_state_checks("R6 power-up");

    // Table walk: R1, R2 order and wrap, R3 readback order and wrap.
    for (int i = 0; i < 16; i++) begin
      if (VEC[i].rd) begin
        rd_op(1'b0, 1'b0);
        check($sformatf("R3 vec%0d dout", i), 32'(dout), 32'(VEC[i].data));
      end else begin
        wr_op(VEC[i].data);
      end
    end
    check("R2 empty_ofs after wrap", 32'(empty_ofs), 32'h3322A5);
    check("R1 full_ofs assembled",   32'(full_ofs),  32'h665544);

    // R4: qualified only when both low.
    rd_op(1'b1, 1'b0);
    check("R4 dout with ld_n high", 32'(dout), 32'h33);
    rd_op(1'b0, 1'b1);
    check("R4 dout with ren_n high", 32'(dout), 32'h33);

    // R5: blocked writes, then resume at next slice (slot 1).
    @(negedge wr_clk); ld_n = 1'b1; wen_n = 1'b0; din = 8'hFF;
    @(negedge wr_clk); ld_n = 1'b0; wen_n = 1'b1;
    @(negedge wr_clk); ld_n = 1'b1; wen_n = 1'b1;
    check("R5 empty_ofs unchanged", 32'(empty_ofs), 32'h3322A5);
    check("R5 full_ofs unchanged",  32'(full_ofs),  32'h665544);
    wr_op(8'h77);
    check("R5 resume empty mid", 32'(empty_ofs), 32'h3377A5);

    // R7: partial reset clears dout only.
    @(negedge wr_clk); prst = 1'b1;
    @(posedge rd_clk);
    @(negedge wr_clk); prst = 1'b0;
    check("R7 dout cleared", 32'(dout), 32'h0);
    check("R7 offsets kept", 32'(full_ofs), 32'h665544);
    wr_op(8'h88);
    check("R7 write ptr kept", 32'(empty_ofs), 32'h8877A5);
    rd_op(1'b0, 1'b0);
    check("R7 read ptr kept", 32'(dout), 32'h44);

    // R8: full validity drop and delayed rise.
    wr_op(8'h01);
    check("R8 vld low after full LSB", 32'(full_ofs_vld), 32'd0);
    wr_op(8'h02);
    wr_op(8'h03);
    check("R8 vld low at msb edge", 32'(full_ofs_vld), 32'd0);
    @(posedge wr_clk); @(negedge wr_clk);
    check("R8 vld low one edge later", 32'(full_ofs_vld), 32'd0);
    @(posedge wr_clk); @(negedge wr_clk);
    check("R8 vld high two edges later", 32'(full_ofs_vld), 32'd1);
    check("R8 full_ofs", 32'(full_ofs), 32'h030201);

    // R3: read pointer independent of write pointer (now at slot 4).
    rd_op(1'b0, 1'b0);
    check("R3 independent read ptr", 32'(dout), 32'h02);

    // R9: empty validity in read domain.
    wr_op(8'h10);
    wait_rd(3);
    check("R9 empty vld low mid-program", 32'(empty_ofs_vld), 32'd0);
    wr_op(8'h20);
    wr_op(8'h30);
    wait_rd(3);
    check("R9 empty vld high after msb", 32'(empty_ofs_vld), 32'd1);
    check("R9 empty_ofs", 32'(empty_ofs), 32'h302010);

    // R6: master reset mid-sequence.
    do_mrst();
    reset_state_checks("R6 mid-run");
    rd_op(1'b0, 1'b0);
    check("R6 read ptr at slot 0", 32'(dout), 32'h07);
    wr_op(8'h5A);
    check("R6 write ptr at slot 0", 32'(empty_ofs), 32'h00005A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule